// File: doc/BRIEF.md
# Low-Speed Serial Bus Packet Receiver

This block pulls packets off a low-speed USB differential pair (D+ and D-) and turns them into a stream of bytes. It runs from a clock eight times the bit rate. Both line inputs pass through a two-flop synchronizer. The receiver then waits for the idle (J) level. It arms on the first K and hunts for the double K that closes the sync field. After that it samples each bit near its centre, undoes the NRZI coding and drops the stuffed bits. Bits are packed least significant first.

Each finished byte is shown for one cycle on `rx_data` with `rx_valid`. A single-ended zero (SE0) ends the packet with an `rx_eop` pulse, and `rx_count` then holds the number of bytes received. There are two ways a reception fails. If the byte budget is exceeded, the packet is aborted with `rx_overflow`. If the sync field is never completed, the attempt is dropped with `rx_sync_err`. The sample phase is re-centred on every D- transition, so modest clock drift does not break a packet.

Top module: `ls_usb_rx`

## Requirements
- R1: After reset every pulse output is low, `rx_active` is low and `rx_count` is 0.
- R2: Line levels are defined as follows. J (idle) is D+=0 with D-=1. K is D+=1 with D-=0. SE0 is both lines low. The receiver first waits for J and arms on the next K. It accepts the sync field K,J,K,J,K,J,K,K (in time order). Data starts with the bit after the final K. `rx_active` is high from then until the packet ends, and `rx_count` is 0 when it rises.
- R3: A J-to-K edge whose following bit is not K is rejected, and the hunt for a later edge carries on.
- R4: If no valid double K is found within SYNC_TIMEOUT clocks (default 96) of the arming K, `rx_sync_err` pulses for one cycle. No byte is produced, and the receiver waits for J again.
- R5: Data is decoded from D- alone. Two equal consecutive samples give a 1, and differing samples give a 0. The closing K of sync is the first reference sample.
- R6: After six consecutive decoded 1 bits, the next bit is dropped. The closing double K of sync counts as one decoded 1 in that run.
- R7: Bits are assembled least significant first. Each completed byte appears on `rx_data` together with a one-cycle `rx_valid`.
- R8: SE0 at a sample point other than the first bit of a byte ends the packet. It gives a one-cycle `rx_eop` with `rx_active` low. `rx_count` then equals the number of bytes delivered in the packet.
- R9: SE0 sampled at the first bit of a byte does not end the packet. It is decoded as a K level.
- R10: When byte MAX_BYTES+1 (default 9) completes, `rx_overflow` pulses and that byte gets no `rx_valid`. `rx_active` drops. The rest of the packet, including its SE0, gives no `rx_eop`. `rx_count` never exceeds MAX_BYTES.
- R11: The sample point sits SAMPLE_PHASE clocks (default 4) after each D- transition. A packet in which every fourth bit lasts 9 clocks instead of 8 is still received correctly.
- R12: At most one of `rx_valid`, `rx_eop`, `rx_overflow` and `rx_sync_err` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at eight times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| usb_dp | input | 1 | D+ line, asynchronous |
| usb_dm | input | 1 | D- line, asynchronous |
| rx_data | output | 8 | Last completed byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| rx_eop | output | 1 | One-cycle end-of-packet strobe |
| rx_overflow | output | 1 | One-cycle byte-budget abort strobe |
| rx_sync_err | output | 1 | One-cycle sync timeout strobe |
| rx_active | output | 1 | High while packet data is being received |
| rx_count | output | $clog2(MAX_BYTES+1) | Bytes delivered in the current or last packet |

## Verification
Most wrong internal states show up quickly at the ports.

- **Sample phase:** if it slips, a wrong byte value appears on `rx_data` within one byte time.
- **Run-of-ones counter:** if it is off, the byte that holds the stuffed bit and every byte after it are shifted by one bit.
- **Bit position:** if it is lost, SE0 either ends the packet early, with a short `rx_count`, or is taken as data, with a missing `rx_eop`.

A wrong sync hunt appears either as an `rx_sync_err` on a good packet or as bytes that follow a sync field that should have been rejected. The bench encodes each packet from the requirements and compares the delivered bytes, the end strobe and the count after every packet.

// File: rtl/ls_usb_rx.sv
module ls_usb_rx #(
  parameter int CLKS_PER_BIT = 8,
  parameter int SAMPLE_PHASE = 4,
  parameter int MAX_BYTES    = 8,
  parameter int SYNC_TIMEOUT = 96
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           usb_dp,
  input  logic                           usb_dm,
  output logic [7:0]                     rx_data,
  output logic                           rx_valid,
  output logic                           rx_eop,
  output logic                           rx_overflow,
  output logic                           rx_sync_err,
  output logic                           rx_active,
  output logic [$clog2(MAX_BYTES+1)-1:0] rx_count
);
  localparam int PW = $clog2(CLKS_PER_BIT);
  localparam int CW = $clog2(MAX_BYTES + 1);
  localparam int TW = $clog2(SYNC_TIMEOUT + 1);

  typedef enum logic [2:0] {S_IDLE, S_ARM, S_HUNT, S_CHECK, S_RECV, S_DRAIN} state_t;

  state_t        state;
  logic [1:0]    dp_ff, dm_ff;
  logic          dm_d, j_d;
  logic [PW-1:0] phase;
  logic [TW-1:0] tmr;
  logic          chk_seen;
  logic          last_dm;
  logic [2:0]    ones;
  logic [2:0]    bitpos;
  logic [7:0]    shreg;
  logic [CW-1:0] nbytes;

  wire dp_s      = dp_ff[1];
  wire dm_s      = dm_ff[1];
  wire line_j    = dm_s & ~dp_s;
  wire line_k    = dp_s & ~dm_s;
  wire line_se0  = ~dp_s & ~dm_s;
  wire dm_edge   = dm_s ^ dm_d;
  wire k_edge    = line_k & j_d;
  wire sample_pt = (phase == PW'(SAMPLE_PHASE));
  wire dec_bit   = (dm_s == last_dm);
  wire [7:0] next_byte = {dec_bit, shreg[7:1]};

  assign rx_active = (state == S_RECV);
  assign rx_count  = nbytes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_ff <= 2'b00;
      dm_ff <= 2'b11;
      dm_d  <= 1'b1;
      j_d   <= 1'b0;
      phase <= '0;
    end else begin
      dp_ff <= {dp_ff[0], usb_dp};
      dm_ff <= {dm_ff[0], usb_dm};
      dm_d  <= dm_s;
      j_d   <= line_j;
      if (dm_edge)
        phase <= PW'(1);
      else if (phase == PW'(CLKS_PER_BIT - 1))
        phase <= '0;
      else
        phase <= phase + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      tmr         <= '0;
      chk_seen    <= 1'b0;
      last_dm     <= 1'b0;
      ones        <= '0;
      bitpos      <= '0;
      shreg       <= '0;
      nbytes      <= '0;
      rx_data     <= '0;
      rx_valid    <= 1'b0;
      rx_eop      <= 1'b0;
      rx_overflow <= 1'b0;
      rx_sync_err <= 1'b0;
    end else begin
      rx_valid    <= 1'b0;
      rx_eop      <= 1'b0;
      rx_overflow <= 1'b0;
      rx_sync_err <= 1'b0;
      case (state)
        S_IDLE: if (line_j) state <= S_ARM;
        S_ARM: if (line_k) begin
          state <= S_HUNT;
          tmr   <= '0;
        end
        S_HUNT, S_CHECK: begin
          tmr <= tmr + 1'b1;
          if (state == S_HUNT && k_edge) begin
            state    <= S_CHECK;
            chk_seen <= 1'b0;
          end else if (state == S_CHECK && sample_pt) begin
            if (!chk_seen)
              chk_seen <= 1'b1;
            else if (line_k) begin
              state   <= S_RECV;
              last_dm <= 1'b0;
              ones    <= 3'd1;
              bitpos  <= '0;
              nbytes  <= '0;
            end else
              state <= S_HUNT;
          end else if (tmr >= TW'(SYNC_TIMEOUT - 1)) begin
            state       <= S_IDLE;
            rx_sync_err <= 1'b1;
          end
        end
        S_RECV: if (sample_pt) begin
          if (line_se0 && bitpos != 3'd0) begin
            state  <= S_IDLE;
            rx_eop <= 1'b1;
          end else begin
            last_dm <= dm_s;
            if (ones == 3'd6)
              ones <= '0;
            else begin
              shreg  <= next_byte;
              ones   <= dec_bit ? ones + 1'b1 : 3'd0;
              bitpos <= bitpos + 1'b1;
              if (bitpos == 3'd7) begin
                if (nbytes == CW'(MAX_BYTES)) begin
                  state       <= S_DRAIN;
                  rx_overflow <= 1'b1;
                end else begin
                  rx_data  <= next_byte;
                  rx_valid <= 1'b1;
                  nbytes   <= nbytes + 1'b1;
                end
              end
            end
          end
        end
        S_DRAIN: if (line_se0) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r12_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_valid, rx_eop, rx_overflow, rx_sync_err}));
  a_r7_valid_in_packet: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> rx_active);
  a_r8_eop_closes: assert property (@(posedge clk) disable iff (!rst_n)
    rx_eop |-> !rx_active);
  a_r10_ovf_closes: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overflow |-> !rx_active);
  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CW'(MAX_BYTES));
  a_r2_start_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_active) |-> rx_count == '0);
  a_r6_run_limit: assert property (@(posedge clk) disable iff (!rst_n)
    ones <= 3'd6);
  a_r4_err_not_active: assert property (@(posedge clk) disable iff (!rst_n)
    rx_sync_err |-> !rx_active);
endmodule

// File: tb/test_ls_usb_rx.sv
`timescale 1ns/1ps
module test_ls_usb_rx;
  localparam int MAXB = 8;
  localparam int CW = $clog2(MAXB + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic usb_dp = 1'b0, usb_dm = 1'b1;
  logic [7:0] rx_data;
  logic rx_valid, rx_eop, rx_overflow, rx_sync_err, rx_active;
  logic [CW-1:0] rx_count;

  always #2.5 clk = ~clk;

  ls_usb_rx #(.MAX_BYTES(MAXB)) i_ls_usb_rx (
    .clk(clk), .rst_n(rst_n), .usb_dp(usb_dp), .usb_dm(usb_dm),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_eop(rx_eop),
    .rx_overflow(rx_overflow), .rx_sync_err(rx_sync_err),
    .rx_active(rx_active), .rx_count(rx_count));

  int checks = 0, errors = 0, cycles = 0;
  int gn = 0, eop_n = 0, ovf_n = 0, serr_n = 0, act_n = 0, eop_last = 0;
  logic [7:0] got [0:63];

  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (rx_valid) begin got[gn % 64] <= rx_data; gn <= gn + 1; end
    if (rx_eop) begin eop_n <= eop_n + 1; eop_last <= int'(rx_count); end
    if (rx_overflow) ovf_n <= ovf_n + 1;
    if (rx_sync_err) serr_n <= serr_n + 1;
    if (rx_active) act_n <= act_n + 1;
  end

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(negedge clk) if (cycles > 150000) begin
    errors++;
    $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
    finish_up();
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h), expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  // levels: 0 = K, 1 = J, 2 = SE0
  logic [1:0] lv [0:1023];
  int nlv;
  logic [7:0] pb [0:15];

  task automatic add(input logic [1:0] l);
    lv[nlv] = l; nlv++;
  endtask

  task automatic build(input int n);
    logic [1:0] cur;
    int ones;
    nlv = 0;
    for (int i = 0; i < 4; i++) add(2'd1);
    for (int i = 0; i < 8; i++) add((i % 2 == 1 && i != 7) ? 2'd1 : 2'd0);
    cur = 2'd0; ones = 1;
    for (int b = 0; b < n; b++)
      for (int k = 0; k < 8; k++) begin
        if (pb[b][k]) begin
          add(cur); ones++;
          if (ones == 6) begin cur = 2'd1 - cur; add(cur); ones = 0; end
        end else begin
          cur = 2'd1 - cur; add(cur); ones = 0;
        end
      end
    add(2'd2); add(2'd2); add(2'd1); add(2'd1);
  endtask

  task automatic drive_level(input logic [1:0] l, input int clks);
    repeat (clks) begin
      @(negedge clk);
      usb_dp = (l == 2'd0);
      usb_dm = (l == 2'd1);
    end
  endtask

  task automatic play(input bit drift);
    for (int i = 0; i < nlv; i++)
      drive_level(lv[i], (drift && (i % 4 == 3)) ? 9 : 8);
    drive_level(2'd1, 24);
  endtask

  task automatic expect_pkt(input string req, input int g0, input int e0, input int o0, input int n);
    check(gn - g0 == n, {req, " byte count"}, gn - g0, n);
    for (int b = 0; b < n; b++)
      check(got[(g0 + b) % 64] == pb[b], {req, " byte value"}, got[(g0 + b) % 64], pb[b]);
    check(eop_n - e0 == 1, {req, " R8 eop"}, eop_n - e0, 1);
    check(eop_last == n, {req, " R8 rx_count"}, eop_last, n);
    check(ovf_n == o0, {req, " no overflow"}, ovf_n, o0);
    check(rx_active == 1'b0, {req, " R2 active low after"}, rx_active, 0);
  endtask

  localparam int NV = 5;
  localparam logic [34:0] VEC [0:NV-1] = '{
    {3'd1, 32'h0000_00A5},
    {3'd2, 32'h0000_3FFF},
    {3'd3, 32'h0081_FF00},
    {3'd4, 32'hC301_FE7E},
    {3'd4, 32'hFFFF_FFFF}
  };

  initial begin
    int g0, e0, o0, s0, a0, n;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(rx_valid == 0 && rx_eop == 0 && rx_overflow == 0 && rx_sync_err == 0, "R1 pulses", 
          {rx_valid, rx_eop, rx_overflow, rx_sync_err}, 0);
    check(rx_active == 0, "R1 active", rx_active, 0);
    check(rx_count == 0, "R1 count", rx_count, 0);
    rst_n = 1'b1;
    drive_level(2'd1, 32);

    // table walk: R2 R3 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      n = int'(VEC[v][34:32]);
      for (int b = 0; b < 4; b++) pb[b] = VEC[v][8*b +: 8];
      g0 = gn; e0 = eop_n; o0 = ovf_n; a0 = act_n;
      build(n);
      play(1'b0);
      expect_pkt("R5 R6 R7 vector", g0, e0, o0, n);
      check(act_n > a0, "R2 active during packet", act_n - a0, 1);
    end

    // R4: arming K held with no further edge
    s0 = serr_n; g0 = gn;
    drive_level(2'd0, 160);
    drive_level(2'd1, 40);
    check(serr_n - s0 == 1, "R4 stuck K timeout", serr_n - s0, 1);
    check(gn == g0, "R4 no bytes", gn - g0, 0);

    // R3 R4: sync pattern lacking the double K
    s0 = serr_n; g0 = gn; e0 = eop_n;
    for (int i = 0; i < 6; i++) drive_level((i % 2 == 0) ? 2'd0 : 2'd1, 8);
    drive_level(2'd1, 128);
    check(serr_n - s0 == 1, "R3 false sync rejected", serr_n - s0, 1);
    check(gn == g0 && eop_n == e0, "R3 no packet", gn - g0, 0);
    check(rx_active == 0, "R4 active low", rx_active, 0);

    // R9: SE0 at the first bit of the second byte
    pb[0] = 8'h00; pb[1] = 8'h01;
    build(2);
    lv[20] = 2'd2;
    g0 = gn; e0 = eop_n; o0 = ovf_n;
    play(1'b0);
    expect_pkt("R9 SE0 at bit 0", g0, e0, o0, 2);

    // R11: drift, every fourth bit stretched
    pb[0] = 8'hFF; pb[1] = 8'h00; pb[2] = 8'hA5; pb[3] = 8'h7F;
    build(4);
    g0 = gn; e0 = eop_n; o0 = ovf_n;
    play(1'b1);
    expect_pkt("R11 drift", g0, e0, o0, 4);

    // R10: overflow
    for (int b = 0; b < MAXB + 1; b++) pb[b] = 8'h30 + 8'(b);
    build(MAXB + 1);
    g0 = gn; e0 = eop_n; o0 = ovf_n;
    play(1'b0);
    check(gn - g0 == MAXB, "R10 bytes before abort", gn - g0, MAXB);
    check(ovf_n - o0 == 1, "R10 overflow pulse", ovf_n - o0, 1);
    check(eop_n == e0, "R10 no eop", eop_n - e0, 0);
    check(rx_active == 0, "R10 active low", rx_active, 0);
    check(int'(rx_count) == MAXB, "R10 count bound", rx_count, MAXB);

    // recovery after abort
    pb[0] = 8'h5A;
    build(1);
    g0 = gn; e0 = eop_n; o0 = ovf_n;
    play(1'b0);
    expect_pkt("R10 recovery", g0, e0, o0, 1);

    finish_up();
  end
endmodule